// File: doc/BRIEF.md
# Five-Channel Wavetable Sound Generator

This block is a memory-mapped wavetable synthesiser. A processor reaches it through a byte-wide bus over a 256-byte window. Through that window it loads small signed waveforms and sets a period, a volume and an on/off bit for each of five voices. On every clock, each enabled voice plays one entry of a 32-entry waveform. The voice moves to the next entry at a rate set by its 12-bit period. The entry is scaled by the voice's 4-bit volume, and the five scaled values are added into one signed sample that is registered at the output.

The waveform store holds four tables. Voices one to three each own a table. Voices four and five play the same fourth table. Period, volume and enable settings can only be written, and they appear twice in the window. A separate read-only range returns the shared table.

Top module: `wave5_synth`

## Requirements
- R1: Offsets 0x00–0x7F read and write four 32-byte tables of signed 8-bit samples. Voice k (k = 1..3) plays the table at 0x20*(k-1). Voices 4 and 5 both play the table at 0x60.
- R2: A read at offset 0xA0–0xDF returns the byte at 0x60 + (offset AND 0x1F). A write in that range changes nothing.
- R3: Reads at 0x80–0x9F and 0xE0–0xFF return 0xFF. Read data appears in the cycle after the read strobe and holds until the next read.
- R4: The period of voice k is written as a low byte at 0x80+2(k-1) and a high nibble at 0x81+2(k-1), bits 3:0. Bits 7:4 of the high byte are ignored. Offsets 0x90–0x9F act exactly like 0x80–0x8F.
- R5: The volume of voice k is written at 0x8A+(k-1). Only bits 3:0 are kept, as an unsigned value.
- R6: Offset 0x8F is the enable register, with bit k-1 switching voice k on. A voice that is off adds 0 to the sum, and its table position is held at entry 0.
- R7: An enabled voice with period P plays each table entry for P+1 clock cycles and then moves to the next entry, wrapping from 31 to 0. The first mixed sample after the enable write uses entry 0.
- R8: mix_out is a 15-bit signed value equal to the sum of sample × volume over the enabled voices. It is registered one cycle after the state it reflects, and it spans from -9600 to +9525 without overflow.
- R9: After reset, every voice is off, all periods and volumes are 0, mix_out is 0 and bus_rdata is 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte offset within the window |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 8 | Read data, valid the cycle after bus_rd |
| mix_out | output | 15 | Signed mixed sample |

## Verification
The properties assume that the bus strobes and the address are known, two-valued levels at every clock edge once reset is released. They also assume that reset is held for at least one edge, so that the registers tracked through $past start from their cleared values. The stimulus drives each strobe for one cycle at a time, changing it on the falling edge, and never raises read and write together. It also fills every waveform byte before any voice is switched on, so no unknown sample ever reaches the sum.

// File: rtl/wave5_pkg.sv
package wave5_pkg;

  // Decoded region of the 256-byte bus window.
  typedef enum logic [1:0] {
    RG_WAVE,    // waveform tables, read/write
    RG_CTRL,    // period/volume/enable, write only (mirrored)
    RG_SHARED,  // read-back of the shared table
    RG_NONE     // reserved
  } region_e;

  function automatic region_e region_of(input logic [7:0] a);
    if (!a[7])             return RG_WAVE;
    if (a[6:5] == 2'b00)   return RG_CTRL;
    if (a[6:5] != 2'b11)   return RG_SHARED;
    return RG_NONE;
  endfunction

endpackage

// File: rtl/wave5_wram.sv
module wave5_wram #(
  parameter int DW  = 8,
  parameter int AW  = 7,
  parameter int NRD = 5
) (
  input  logic              clk,
  input  logic              cpu_we,
  input  logic              cpu_re,
  input  logic [AW-1:0]     cpu_addr,
  input  logic [DW-1:0]     cpu_wdata,
  output logic [DW-1:0]     cpu_q,
  input  logic [NRD*AW-1:0] pb_addr,
  output logic [NRD*DW-1:0] pb_data
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // Processor port: synchronous write, registered read.
  always_ff @(posedge clk) begin
    if (cpu_we) mem[cpu_addr] <= cpu_wdata;
    if (cpu_re) cpu_q <= mem[cpu_addr];
  end

  // One asynchronous playback tap per voice.
  for (genvar g = 0; g < NRD; g++) begin : g_tap
    assign pb_data[g*DW +: DW] = mem[pb_addr[g*AW +: AW]];
  end

endmodule

// File: rtl/wave5_ctrl.sv
module wave5_ctrl #(
  parameter int NCH = 5,
  parameter int DW  = 8,
  parameter int PW  = 12,
  parameter int VW  = 4,
  parameter int IW  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [IW-1:0]     idx,
  input  logic [DW-1:0]     wdata,
  output logic [NCH*PW-1:0] period,
  output logic [NCH*VW-1:0] vol,
  output logic [NCH-1:0]    en
);
  localparam int HW       = PW - DW;
  localparam int VOL_BASE = 2 * NCH;
  localparam int EN_IDX   = 3 * NCH;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [DW-1:0] per_lo;
    logic [HW-1:0] per_hi;
    logic [VW-1:0] vol_r;

    always_ff @(posedge clk) begin
      if (rst) begin
        per_lo <= '0;
        per_hi <= '0;
        vol_r  <= '0;
      end else if (wr) begin
        if (idx == IW'(2*c))        per_lo <= wdata;
        if (idx == IW'(2*c + 1))    per_hi <= wdata[HW-1:0];
        if (idx == IW'(VOL_BASE+c)) vol_r  <= wdata[VW-1:0];
      end
    end

    assign period[c*PW +: PW] = {per_hi, per_lo};
    assign vol[c*VW +: VW]    = vol_r;

    AST_VOL_LOAD: assert property (@(posedge clk) disable iff (rst)
      wr && idx == IW'(VOL_BASE+c) |=> vol_r == $past(wdata[VW-1:0])); // R5
  end

  always_ff @(posedge clk) begin
    if (rst)                           en <= '0;
    else if (wr && idx == IW'(EN_IDX)) en <= wdata[NCH-1:0];
  end

endmodule

// File: rtl/wave5_voice.sv
module wave5_voice #(
  parameter int PW = 12,
  parameter int LW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [PW-1:0] period,
  output logic [LW-1:0] idx
);
  logic [PW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      idx <= '0;
    end else if (!en) begin
      cnt <= period;
      idx <= '0;
    end else if (cnt == '0) begin
      cnt <= period;
      idx <= idx + LW'(1);
    end else begin
      cnt <= cnt - PW'(1);
    end
  end

  AST_IDLE_HOME: assert property (@(posedge clk) disable iff (rst)
    !en |=> idx == '0); // R6

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (rst)
    en && $past(en) && idx != $past(idx) |-> idx == $past(idx) + LW'(1)); // R7

endmodule

// File: rtl/wave5_synth.sv
module wave5_synth #(
  parameter int NCH   = 5,
  parameter int NWAVE = 4,
  parameter int WLEN  = 32,
  parameter int DW    = 8,
  parameter int PW    = 12,
  parameter int VW    = 4,
  parameter int OW    = 15
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [7:0]           bus_addr,
  input  logic [DW-1:0]        bus_wdata,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  output logic [DW-1:0]        bus_rdata,
  output logic signed [OW-1:0] mix_out
);
  import wave5_pkg::*;

  localparam int LW  = $clog2(WLEN);
  localparam int TW  = $clog2(NWAVE);
  localparam int AW  = TW + LW;
  localparam int PRW = DW + VW + 1;

  region_e           region;
  logic [AW-1:0]     ram_addr;
  logic              ram_we, ram_re;
  logic [DW-1:0]     ram_q;
  logic              rd_wave_q;
  logic [NCH*PW-1:0] period;
  logic [NCH*VW-1:0] vol;
  logic [NCH-1:0]    en;
  logic [NCH*AW-1:0] pb_addr;
  logic [NCH*DW-1:0] pb_data;
  logic signed [PRW-1:0] prod [NCH];
  logic signed [OW-1:0]  acc;

  assign region   = region_of(bus_addr);
  assign ram_addr = (region == RG_WAVE) ? bus_addr[AW-1:0]
                  : (AW'((NWAVE-1) * WLEN) | AW'(bus_addr[LW-1:0]));
  assign ram_we   = bus_wr && (region == RG_WAVE);
  assign ram_re   = bus_rd && (region == RG_WAVE || region == RG_SHARED);

  wave5_wram #(.DW(DW), .AW(AW), .NRD(NCH)) u_wram (
    .clk(clk), .cpu_we(ram_we), .cpu_re(ram_re), .cpu_addr(ram_addr),
    .cpu_wdata(bus_wdata), .cpu_q(ram_q), .pb_addr(pb_addr), .pb_data(pb_data)
  );

  wave5_ctrl #(.NCH(NCH), .DW(DW), .PW(PW), .VW(VW), .IW(4)) u_ctrl (
    .clk(clk), .rst(rst), .wr(bus_wr && region == RG_CTRL),
    .idx(bus_addr[3:0]), .wdata(bus_wdata),
    .period(period), .vol(vol), .en(en)
  );

  // Read data: table byte when the last read hit a table, otherwise all ones.
  always_ff @(posedge clk) begin
    if (rst)         rd_wave_q <= 1'b0;
    else if (bus_rd) rd_wave_q <= ram_re;
  end
  assign bus_rdata = rd_wave_q ? ram_q : '1;

  for (genvar c = 0; c < NCH; c++) begin : g_voice
    localparam int TBL = (c < NWAVE) ? c : NWAVE - 1;
    logic [LW-1:0] idx;

    wave5_voice #(.PW(PW), .LW(LW)) u_voice (
      .clk(clk), .rst(rst), .en(en[c]),
      .period(period[c*PW +: PW]), .idx(idx)
    );

    assign pb_addr[c*AW +: AW] = {TW'(TBL), idx};
    assign prod[c] = en[c]
      ? PRW'($signed(pb_data[c*DW +: DW])) * PRW'($signed({1'b0, vol[c*VW +: VW]}))
      : '0;
  end

  always_comb begin
    acc = '0;
    for (int c = 0; c < NCH; c++) acc = acc + OW'(prod[c]);
  end

  always_ff @(posedge clk) begin
    if (rst) mix_out <= '0;
    else     mix_out <= acc;
  end

  AST_RSVD_FF: assert property (@(posedge clk) disable iff (rst)
    bus_rd && (region == RG_CTRL || region == RG_NONE) |=> bus_rdata == 8'hFF); // R3

  AST_SILENT: assert property (@(posedge clk) disable iff (rst)
    en == '0 |=> mix_out == '0); // R6

endmodule

// File: tb/wave5_synth_bench.sv
module wave5_synth_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_rdata;
  logic signed [14:0] mix_out;

  always #5 clk = ~clk;

  wave5_synth u_wave5_synth (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .mix_out(mix_out)
  );

  typedef struct {
    bit    is_mix;
    string tag;
    int    exp;
  } item_t;

  item_t sb_q[$];
  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  // Bench model of what has been written
  logic [7:0] wm [128];
  int pm [5];
  int vm [5];
  logic [4:0] enm = '0;

  // Monitor: compares results against queued expectations
  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      nchk++;
      if (it.is_mix) begin
        if (int'(mix_out) != it.exp) begin
          nfail++;
          $display("FAIL %s mix_out actual=%0d expected=%0d", it.tag, mix_out, it.exp);
        end
      end else if (bus_rdata != it.exp[7:0]) begin
        nfail++;
        $display("FAIL %s bus_rdata actual=%02h expected=%02h", it.tag, bus_rdata, it.exp[7:0]);
      end
    end
  end

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic wave_put(input logic [7:0] a, input logic [7:0] d);
    wm[a[6:0]] = d;
    bus_write(a, d);
  endtask

  task automatic read_expect(input logic [7:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(posedge clk);
    sb_q.push_back('{is_mix: 1'b0, tag: tag, exp: int'(e)});
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  function automatic int exp_mix(input int m);
    int sum = 0;
    for (int c = 0; c < 5; c++) begin
      if (enm[c]) begin
        int base = ((c < 3) ? c : 3) * 32;
        int pos  = ((m - 1) / (pm[c] + 1)) % 32;
        int s    = $signed(wm[base + pos]);
        sum += s * vm[c];
      end
    end
    return sum;
  endfunction

  // Call right after the enabling write; checks mixed samples m = 1..n
  task automatic run_mix(input int n, input string tag);
    for (int m = 1; m <= n; m++) begin
      @(posedge clk);
      sb_q.push_back('{is_mix: 1'b1, tag: tag, exp: exp_mix(m)});
    end
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    nfail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    for (int c = 0; c < 5; c++) begin pm[c] = 0; vm[c] = 0; end
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R9: reset state
    @(posedge clk);
    sb_q.push_back('{is_mix: 1'b1, tag: "R9", exp: 0});
    @(negedge clk);
    if (bus_rdata != 8'hFF) begin
      nfail++;
      $display("FAIL R9 bus_rdata actual=%02h expected=ff", bus_rdata);
    end
    nchk++;

    // R1: fill all tables, read back
    for (int i = 0; i < 128; i++) wave_put(8'(i), 8'(i*37 + 11));
    read_expect(8'h00, wm[8'h00], "R1");
    read_expect(8'h1F, wm[8'h1F], "R1");
    read_expect(8'h45, wm[8'h45], "R1");
    read_expect(8'h7F, wm[8'h7F], "R1");

    // R2: shared read window, writes there ignored
    read_expect(8'hA3, wm[8'h63], "R2");
    read_expect(8'hC3, wm[8'h63], "R2");
    read_expect(8'hDF, wm[8'h7F], "R2");
    bus_write(8'hA3, 8'h55);
    read_expect(8'h63, wm[8'h63], "R2");

    // R3: write-only and reserved reads
    bus_write(8'h82, 8'h12);
    read_expect(8'h82, 8'hFF, "R3");
    read_expect(8'h8F, 8'hFF, "R3");
    read_expect(8'h9A, 8'hFF, "R3");
    read_expect(8'hE0, 8'hFF, "R3");
    read_expect(8'hFF, 8'hFF, "R3");
    // R3: read data holds after the strobe
    read_expect(8'h10, wm[8'h10], "R3");
    @(negedge clk);
    if (bus_rdata != wm[8'h10]) begin
      nfail++;
      $display("FAIL R3 held bus_rdata actual=%02h expected=%02h", bus_rdata, wm[8'h10]);
    end
    nchk++;
    bus_write(8'h82, 8'h00);

    // R4/R5/R7/R8: voice 1, period 2 (high nibble junk), volume 3 (high nibble junk)
    bus_write(8'h80, 8'h02);
    bus_write(8'h81, 8'hF0);
    bus_write(8'h8A, 8'hF3);
    pm[0] = 2; vm[0] = 3; enm = 5'b00001;
    bus_write(8'h8F, 8'h01);
    run_mix(100, "R7");

    // R6: switched off contributes nothing
    enm = 5'b0;
    bus_write(8'h8F, 8'h00);
    run_mix(3, "R6");

    // R4 mirror: voices 2 and 3 through 0x90-0x9F and direct offsets
    bus_write(8'h92, 8'h01);
    bus_write(8'h93, 8'h00);
    bus_write(8'h9B, 8'h07);
    bus_write(8'h84, 8'h00);
    bus_write(8'h85, 8'h00);
    bus_write(8'h8C, 8'h02);
    pm[1] = 1; vm[1] = 7; pm[2] = 0; vm[2] = 2; enm = 5'b00110;
    bus_write(8'h8F, 8'hE6);  // bits 7:5 have no voice
    run_mix(40, "R4");

    // R1: voices 4 and 5 share one table
    enm = 5'b0;
    bus_write(8'h8F, 8'h00);
    bus_write(8'h86, 8'h03);
    bus_write(8'h87, 8'h00);
    bus_write(8'h88, 8'h03);
    bus_write(8'h89, 8'h00);
    bus_write(8'h8D, 8'h01);
    bus_write(8'h8E, 8'h02);
    pm[3] = 3; vm[3] = 1; pm[4] = 3; vm[4] = 2; enm = 5'b11000;
    bus_write(8'h8F, 8'h18);
    run_mix(20, "R1");

    // R8: extremes with all five voices at full volume
    enm = 5'b0;
    bus_write(8'h8F, 8'h00);
    for (int c = 0; c < 5; c++) begin
      bus_write(8'(8'h80 + 2*c), 8'hFF);
      bus_write(8'(8'h81 + 2*c), 8'h0F);
      bus_write(8'(8'h8A + c), 8'h0F);
      pm[c] = 4095; vm[c] = 15;
    end
    for (int t = 0; t < 4; t++) wave_put(8'(t*32), 8'h80);
    enm = 5'b11111;
    bus_write(8'h8F, 8'h1F);
    run_mix(4, "R8");
    @(posedge clk);
    sb_q.push_back('{is_mix: 1'b1, tag: "R8", exp: -9600});
    @(negedge clk);
    enm = 5'b0;
    bus_write(8'h8F, 8'h00);
    for (int t = 0; t < 4; t++) wave_put(8'(t*32), 8'h7F);
    enm = 5'b11111;
    bus_write(8'h8F, 8'h1F);
    run_mix(4, "R8");
    @(posedge clk);
    sb_q.push_back('{is_mix: 1'b1, tag: "R8", exp: 9525});
    @(negedge clk);

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule